// File: doc/BRIEF.md
# GPIO Pin Control Register Bank with Combined Interrupt

This block holds one 32-bit control and status word for each of a small number of general-purpose pins. The words sit on a simple register bus. Software uses them to drive a pin, to read its level, and to arm an interrupt on an edge or on a level. The block does not filter the input. It samples it and then checks, on every cycle, whether the pin's trigger condition is met. When the condition is met, a sticky pending bit is set. Software clears that bit by writing a 1 to it.

The pending bits of all pins are gated by their enable and mask bits and merged into one registered interrupt line. A master word at offset 0xFC carries an end-of-interrupt bit. Writing it drops the line for one cycle, so an interrupt that is still pending gives the upstream controller a fresh rising edge. Software needs no acknowledge step before it services a pin. The debounce settings and the pad electrical settings are stored and read back, but they have no effect on the logic.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every pin word reads 0, `pad_oe` and `pad_out` are 0 and `irq_out` is 0 (with `pad_in` low).
- R2: Pin p's word is at byte address 4*p. Address 0xFC is the master word, which reads 0. Any other address reads 0. The writable fields are bits [15:0] and [25:17], and they read back exactly as written. Bits 26, 27, 30 and 31 always read 0.
- R3: `pad_out[p]` follows bit 22 and `pad_oe[p]` follows bit 23 of pin p's word, starting on the cycle after the write.
- R4: Bit 16 is read-only. It shows the effective input one clock after the input changes. The effective input is bit 24 when bit 25 is 1, and `pad_in[p]` otherwise.
- R5: In edge mode (bit 8 = 0), bits [10:9] choose the trigger: 0 = rising, 1 = falling, 2 = both edges, 3 = rising. A trigger sets bit 28 only while bit 11 (interrupt enable) is 1. The bit becomes visible two clocks after the input change.
- R6: In level mode (bit 8 = 1), bits [10:9] = 1 mean active low and any other value means active high. Bit 28 is set again on every cycle in which the input is at its active level.
- R7: Writing 1 to bit 28 clears it. Writing 0 leaves it unchanged. When a clear and a new trigger fall on the same cycle, the status stays set.
- R8: Bit 29 (wake status) is set by any detected trigger while bits [15:13] are nonzero, whatever the interrupt enable. Writing 1 to bit 29 clears it.
- R9: `irq_out` is the OR over all pins of (bit 28 AND bit 11 AND NOT bit 12), registered once. It therefore rises three clocks after the input edge.
- R10: Writing 1 to bit 29 of the master word forces `irq_out` low for exactly the next cycle. After that cycle the line follows R9 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pad_in | input | NUM_PINS | Already-filtered pin inputs |
| pad_out | output | NUM_PINS | Output value per pin |
| pad_oe | output | NUM_PINS | Output enable per pin |
| irq_out | output | 1 | Combined interrupt line |

## Verification
A stuck or wrongly set pending bit shows at bit 28 two clocks after the input change and on `irq_out` one clock later. The bench therefore samples at a fixed three-cycle distance, so an off-by-one register stage or a missing edge qualifier shows up as a mismatch at once. A wrong write-1-to-clear path shows on the first read after the clear. The level re-set and set-over-clear ordering show on the read taken in the same cycle as the clear. A broken end-of-interrupt blanking is visible on `irq_out` in the single cycle after the master write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_W = 32;

  // bit positions decoded by software
  localparam int B_LEVEL = 8;
  localparam int B_ACT0  = 9;
  localparam int B_IEN   = 11;
  localparam int B_IMSK  = 12;
  localparam int B_WAKE0 = 13;
  localparam int B_INLVL = 16;
  localparam int B_OVAL  = 22;
  localparam int B_OEN   = 23;
  localparam int B_SWVAL = 24;
  localparam int B_SWEN  = 25;
  localparam int B_ISTS  = 28;
  localparam int B_WSTS  = 29;
  localparam int B_EOI   = 29;

  localparam logic [REG_W-1:0] WR_MASK = 32'h03FE_FFFF;
  localparam logic [7:0] MASTER_OFS = 8'hFC;

  localparam logic [1:0] ACT_HIGH = 2'd0;
  localparam logic [1:0] ACT_LOW  = 2'd1;
  localparam logic [1:0] ACT_BOTH = 2'd2;

  // trigger condition on sampled input (cur) and previous sample (old)
  function automatic logic trig_hit(input logic lvl, input logic [1:0] act,
                                    input logic cur, input logic old);
    logic r;
    if (lvl) begin
      r = (act == ACT_LOW) ? ~cur : cur;
    end else begin
      case (act)
        ACT_LOW:  r = ~cur & old;
        ACT_BOTH: r = cur ^ old;
        default:  r = cur & ~old;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec #(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_PINS-1:0] pin_sel,
  output logic                master_hit
);
  import gpio_bank_pkg::*;

  localparam logic [ADDR_W-1:0] MASTER_ADDR = ADDR_W'(MASTER_OFS);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sel
    assign pin_sel[p] = (addr == ADDR_W'(p * 4));
  end

  assign master_hit = (addr == MASTER_ADDR);
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pad_i,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rd_word,
  output logic             pad_o,
  output logic             oe_o,
  output logic             pend_o
);
  logic [REG_W-1:0] cfg_q;
  logic samp_q, prev_q, ists_q, wsts_q;
  logic eff_in, hit_w, set_evt, wake_evt, clr_req, wclr_req;

  assign eff_in   = cfg_q[B_SWEN] ? cfg_q[B_SWVAL] : pad_i;
  assign hit_w    = trig_hit(cfg_q[B_LEVEL], cfg_q[B_ACT0+:2], samp_q, prev_q);
  assign set_evt  = hit_w & cfg_q[B_IEN];
  assign wake_evt = hit_w & (|cfg_q[B_WAKE0+:3]);
  assign clr_req  = wr_stb & wdata[B_ISTS];
  assign wclr_req = wr_stb & wdata[B_WSTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      samp_q <= 1'b0;
      prev_q <= 1'b0;
      ists_q <= 1'b0;
      wsts_q <= 1'b0;
    end else begin
      if (wr_stb) cfg_q <= wdata & WR_MASK;
      samp_q <= eff_in;
      prev_q <= samp_q;
      ists_q <= set_evt | (ists_q & ~clr_req);
      wsts_q <= wake_evt | (wsts_q & ~wclr_req);
    end
  end

  always_comb begin
    rd_word          = cfg_q;
    rd_word[B_INLVL] = samp_q;
    rd_word[B_ISTS]  = ists_q;
    rd_word[B_WSTS]  = wsts_q;
  end

  assign pad_o  = cfg_q[B_OVAL];
  assign oe_o   = cfg_q[B_OEN];
  assign pend_o = ists_q & cfg_q[B_IEN] & ~cfg_q[B_IMSK];

  AST_SET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> ists_q); // R5
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !ists_q); // R7
  AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !set_evt) |=> $stable(ists_q)); // R7
  AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> wsts_q); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ists_q) |-> $past(set_evt)); // R5
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pend_vec,
  input  logic                eoi,
  output logic                irq_o
);
  logic any_pend;
  assign any_pend = |pend_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= eoi ? 1'b0 : any_pend;
  end

  AST_EOI_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !irq_o); // R10
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (any_pend && !eoi) |=> irq_o); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(any_pend)); // R9
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq_out
);
  logic [NUM_PINS-1:0] pin_sel;
  logic                master_hit;
  logic [NUM_PINS-1:0] pend_vec;
  logic [REG_W-1:0]    rd_words [NUM_PINS];
  logic                eoi_pulse;

  gpio_addr_dec #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .pin_sel(pin_sel), .master_hit(master_hit)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_cell u_cell (
      .clk(clk), .rst_n(rst_n), .pad_i(pad_in[p]),
      .wr_stb(bus_wr & pin_sel[p]), .wdata(bus_wdata),
      .rd_word(rd_words[p]), .pad_o(pad_out[p]), .oe_o(pad_oe[p]),
      .pend_o(pend_vec[p])
    );
  end

  assign eoi_pulse = bus_wr & master_hit & bus_wdata[B_EOI];

  gpio_irq_merge #(.NUM_PINS(NUM_PINS)) u_merge (
    .clk(clk), .rst_n(rst_n), .pend_vec(pend_vec), .eoi(eoi_pulse), .irq_o(irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (pin_sel[p]) bus_rdata = rd_words[p];
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[27:26] == 2'b00) && (bus_rdata[31:30] == 2'b00)); // R2
  AST_MASTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    master_hit |-> (bus_rdata == '0)); // R2
endmodule

// File: tb/gpio_bank_regs_tb.sv
module gpio_bank_regs_tb;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [N-1:0] pad_in = 0, pad_out, pad_oe;
  logic irq_out;
  int total = 0, bad = 0;
  bit done = 0;
  logic [N-1:0] lvl_m = 0;

  always #5 clk = ~clk;

  gpio_bank_regs #(.NUM_PINS(N), .ADDR_W(8)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic setpad(input int p, input logic v);
    @(negedge clk); pad_in[p] = v;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic exp_hit(input logic [1:0] act, input logic o, input logic c);
    case (act)
      2'd1: return o & ~c;
      2'd2: return o ^ c;
      default: return ~o & c;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    cyc(3); rst_n = 1; cyc(2);
    // R1 reset state
    rd(8'h00, d); chk("R1 word0", d, 0);
    chk("R1 oe", {28'b0, pad_oe}, 0);
    chk("R1 irq", {31'b0, irq_out}, 0);
    // R2/R3/R4 readback, software override
    wr(8'h08, 32'hFFFF_10FF); cyc(2);
    rd(8'h08, d); chk("R2 readback mask", d, 32'h03FF_10FF);
    chk("R3 pad_out", {31'b0, pad_out[2]}, 1);
    chk("R3 pad_oe", {31'b0, pad_oe[2]}, 1);
    chk("R4 sw override", {31'b0, d[16]}, 1);
    wr(8'h08, 32'h0); cyc(2);
    rd(8'h40, d); chk("R2 unmapped", d, 0);
    rd(8'hFC, d); chk("R2 master reads 0", d, 0);
    // R4 status timing
    setpad(3, 1); lvl_m[3] = 1;
    @(posedge clk); #1 bus_addr = 8'h0C; #1 chk("R4 level one clock", {31'b0, bus_rdata[16]}, 1);
    setpad(3, 0); lvl_m[3] = 0; cyc(3);
    // R5/R9 random edge triggers
    for (int it = 0; it < 60; it++) begin
      int p; logic [1:0] act; logic en, msk, nv, hit;
      p = $urandom_range(0, N-1); act = 2'($urandom_range(0, 3));
      en = 1'($urandom_range(0, 1)); msk = 1'($urandom_range(0, 1));
      nv = 1'($urandom_range(0, 1));
      wr(8'(p*4), 32'h1000_0000 | ({30'b0, act} << 9) | ({31'b0, en} << 11) | ({31'b0, msk} << 12));
      setpad(p, nv); cyc(3);
      hit = exp_hit(act, lvl_m[p], nv) & en;
      lvl_m[p] = nv;
      rd(8'(p*4), d);
      chk("R5 edge status", {31'b0, d[28]}, {31'b0, hit});
      chk("R4 level", {31'b0, d[16]}, {31'b0, nv});
      chk("R9 irq", {31'b0, irq_out}, {31'b0, hit & ~msk});
      wr(8'(p*4), 32'h1000_0000); cyc(2);
    end
    for (int p = 0; p < N; p++) begin setpad(p, 0); lvl_m[p] = 0; end
    cyc(3);
    // R6/R7 level mode active low
    setpad(1, 1); cyc(3);
    wr(8'h04, 32'h1000_0B00); cyc(3);
    rd(8'h04, d); chk("R6 inactive level", {31'b0, d[28]}, 0);
    setpad(1, 0); cyc(3);
    rd(8'h04, d); chk("R6 active low set", {31'b0, d[28]}, 1);
    chk("R9 irq level", {31'b0, irq_out}, 1);
    wr(8'h04, 32'h1000_0B00); #1;
    chk("R7 set beats clear", {31'b0, bus_rdata[28]}, 1);
    setpad(1, 1); cyc(3);
    wr(8'h04, 32'h1000_0B00); #1;
    chk("R6 cleared when inactive", {31'b0, bus_rdata[28]}, 0);
    wr(8'h04, 32'h1000_0000); setpad(1, 0); cyc(3);
    // R7 write 0 keeps status; R10 EOI
    wr(8'h00, 32'h0000_0800); setpad(0, 1); cyc(3);
    wr(8'h00, 32'h0000_0800); cyc(1);
    rd(8'h00, d); chk("R7 write0 keeps", {31'b0, d[28]}, 1);
    chk("R9 irq pending", {31'b0, irq_out}, 1);
    wr(8'hFC, 32'h2000_0000); #1;
    chk("R10 eoi low", {31'b0, irq_out}, 0);
    @(posedge clk); #1 chk("R10 eoi relaunch", {31'b0, irq_out}, 1);
    wr(8'h00, 32'h0000_1800); cyc(1); #1;
    chk("R9 masked", {31'b0, irq_out}, 0);
    wr(8'h00, 32'h1000_0000); cyc(2);
    rd(8'h00, d); chk("R7 w1c", {31'b0, d[28]}, 0);
    setpad(0, 0); cyc(3);
    // R8 wake status
    wr(8'h0C, 32'h0000_2000); setpad(3, 1); cyc(3);
    rd(8'h0C, d); chk("R8 wake set", {30'b0, d[29:28]}, 2'b10);
    wr(8'h0C, 32'h2000_2000); cyc(1);
    rd(8'h0C, d); chk("R8 wake w1c", {31'b0, d[29]}, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule